// File: doc/BRIEF.md
# Burst SRAM Access and Select Controller

This block is the synchronous control front end of a pipelined SRAM-style memory. On every clock edge it samples a two-bit command (deselect, read, write or continue), an external word address and three enables. A read or write that finds the device selected latches the address as the base of a new burst. Each later continue moves to the next of four words. The order is linear on the two low address bits and wraps inside an aligned group of four, so the upper bits never change during a burst.

Selection combines a fixed active-low primary enable with two bank enables. The active level of each bank enable is set by a static strap input. A bank enable bit is active when it equals its strap bit. Four copies strapped 00, 01, 10 and 11, with their bank enables driven from two address lines, give four-bank depth expansion and need no decode logic. The block registers three outputs: the internal word address, a read data output enable, and an echo-clock output enable. The echo clocks are released to high impedance only when a bank enable removes the device. They keep running when only the primary enable is inactive.

Top module: `sram_burst_ctl`

## Requirements
- R1: A read (cmd_i=2'b01) or write (cmd_i=2'b10) in a selected cycle opens a burst, and in the next cycle addr_o equals the addr_i of that cycle.
- R2: A continue (cmd_i=2'b11) in a selected cycle with a burst open adds 1 modulo 4 to addr_o[1:0] in the next cycle and leaves addr_o[AW-1:2] unchanged.
- R3: After three continues have stepped through all four words, a fourth continue returns addr_o to the base address of the burst.
- R4: Bank enable bit k is active when bank_en_i[k] equals bank_pol_i[k]. The device is selected when sel_ni is 0 and both bank bits are active. A read, write or deselect (2'b00) in a cycle that is not selected closes the burst, and so does a deselect in a selected cycle.
- R5: For each value driven on bank_en_i, exactly one of the four strap settings 00, 01, 10 and 11 selects the device.
- R6: A continue that arrives when the device is not selected, or when no burst is open (after reset or after a close), is ignored. addr_o holds its value, rd_oe_o is 0 in the next cycle, and an open burst stays open.
- R7: cq_oe_o is 0 in the cycle after an inactive bank enable bit, whatever sel_ni is. It is 1 in the cycle after both bank bits are active, even when sel_ni is 1.
- R8: rd_oe_o is 1 only in the cycle after a selected read or an accepted continue of a read burst. It is 0 after a write, after a continue of a write burst, after a deselect and after an ignored continue.
- R9: While rst_ni is low, addr_o is 0, rd_oe_o is 0, cq_oe_o is 1, and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Command: 00 deselect, 01 read, 10 write, 11 continue |
| addr_i | input | AW | External word address |
| sel_ni | input | 1 | Primary enable, active low, fixed polarity |
| bank_en_i | input | 2 | Bank enables with programmable polarity |
| bank_pol_i | input | 2 | Static straps that set the active level of each bank enable |
| addr_o | output | AW | Internal word address |
| rd_oe_o | output | 1 | Read data output enable |
| cq_oe_o | output | 1 | Echo-clock output enable (0 means high impedance) |

## Verification
The bench runs bursts that start at every low-bit offset and issues a fourth continue to check the wrap. A counter that carried into the upper bits, or that stopped at 11, would end on a wrong address. Continues are sent after reset, after a deselect and while the device is unselected. A design that accepted them would step the address or assert rd_oe_o. Writes are mixed with read bursts to catch an output enable that stays high after a write. All sixteen strap and enable pairs are swept to confirm that each bank value selects exactly one device. Primary-enable and bank-enable deselects are separated, which exposes an echo-clock enable tied to the wrong enable.

// File: rtl/sram_burst_ctl_pkg.sv
package sram_burst_ctl_pkg;
  typedef enum logic [1:0] {
    CMD_DESEL = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_CONT  = 2'b11
  } cmd_e;
endpackage

// File: rtl/bank_decode.sv
module bank_decode #(
  parameter int NB = 2
) (
  input  logic          prim_ni,
  input  logic [NB-1:0] en_i,
  input  logic [NB-1:0] pol_i,
  output logic          sel_o,
  output logic          prog_off_o
);
  logic [NB-1:0] act;

  for (genvar k = 0; k < NB; k++) begin : g_bit
    // strap high: active-high enable; strap low: active-low enable
    assign act[k] = ~(en_i[k] ^ pol_i[k]);
  end

  assign prog_off_o = ~&act;
  assign sel_o      = ~prim_ni & (&act);
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int AW = 18,
  parameter int LW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          close_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic          open_o,
  output logic          rd_burst_o
);
  localparam int UW = AW - LW;

  logic [AW-1:0] base_q;
  logic [LW-1:0] cnt_q;
  logic          open_q;
  logic          rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      open_q <= 1'b0;
      rd_q   <= 1'b0;
    end else if (load_i) begin
      base_q <= addr_i;
      cnt_q  <= '0;
      open_q <= 1'b1;
      rd_q   <= rd_i;
    end else if (step_i && open_q) begin
      cnt_q  <= cnt_q + LW'(1);
    end else if (close_i) begin
      open_q <= 1'b0;
    end
  end

  // linear order: low bits add the count and wrap; the upper bits stay put
  logic [LW-1:0] low;
  assign low        = base_q[LW-1:0] + cnt_q;
  assign addr_o     = {base_q[AW-1:LW], low};
  assign open_o     = open_q;
  assign rd_burst_o = rd_q;

  logic [UW-1:0] unused_chk;
  assign unused_chk = base_q[AW-1:LW];
endmodule

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
  import sram_burst_ctl_pkg::*;
#(
  parameter int AW = 18,
  parameter int LW = 2,
  parameter int NB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    cmd_i,
  input  logic [AW-1:0] addr_i,
  input  logic          sel_ni,
  input  logic [NB-1:0] bank_en_i,
  input  logic [NB-1:0] bank_pol_i,
  output logic [AW-1:0] addr_o,
  output logic          rd_oe_o,
  output logic          cq_oe_o
);
  logic sel, prog_off;
  logic load, step, close_b;
  logic burst_open, rd_burst;
  cmd_e cmd;

  assign cmd = cmd_e'(cmd_i);

  bank_decode #(.NB(NB)) u_dec (
    .prim_ni    (sel_ni),
    .en_i       (bank_en_i),
    .pol_i      (bank_pol_i),
    .sel_o      (sel),
    .prog_off_o (prog_off)
  );

  assign load    = sel && (cmd == CMD_READ || cmd == CMD_WRITE);
  assign step    = sel && (cmd == CMD_CONT) && burst_open;
  assign close_b = (cmd != CMD_CONT) && !load;

  burst_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .step_i     (step),
    .close_i    (close_b),
    .rd_i       (cmd == CMD_READ),
    .addr_i     (addr_i),
    .addr_o     (addr_o),
    .open_o     (burst_open),
    .rd_burst_o (rd_burst)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_oe_o <= 1'b0;
      cq_oe_o <= 1'b1;
    end else begin
      rd_oe_o <= (load && cmd == CMD_READ) || (step && rd_burst);
      cq_oe_o <= !prog_off;
    end
  end
endmodule

// File: rtl/sram_burst_ctl_chk.sv
module sram_burst_ctl_chk #(
  parameter int AW = 18,
  parameter int LW = 2,
  parameter int NB = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    cmd_i,
  input logic [AW-1:0] addr_i,
  input logic          sel_ni,
  input logic [NB-1:0] bank_en_i,
  input logic [NB-1:0] bank_pol_i,
  input logic [AW-1:0] addr_o,
  input logic          rd_oe_o,
  input logic          cq_oe_o,
  input logic          open_i
);
  logic banks_on, selected;
  assign banks_on = (bank_en_i == bank_pol_i);
  assign selected = !sel_ni && banks_on;

  // R1
  a_r1_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (selected && (cmd_i == 2'b01 || cmd_i == 2'b10)) |=> (addr_o == $past(addr_i)));

  // R2
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (selected && cmd_i == 2'b11 && open_i) |=>
      ((addr_o[LW-1:0] == $past(addr_o[LW-1:0]) + LW'(1)) && $stable(addr_o[AW-1:LW])));

  // R6
  a_r6_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'b11 && !(selected && open_i)) |=> ($stable(addr_o) && !rd_oe_o));

  // R7
  a_r7_cq_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !banks_on |=> !cq_oe_o);
  a_r7_cq_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    banks_on |=> cq_oe_o);

  // R8
  a_r8_no_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'b10 || cmd_i == 2'b00 || !selected) |=> !rd_oe_o);
endmodule

bind sram_burst_ctl sram_burst_ctl_chk #(.AW(AW), .LW(LW), .NB(NB)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_i      (cmd_i),
  .addr_i     (addr_i),
  .sel_ni     (sel_ni),
  .bank_en_i  (bank_en_i),
  .bank_pol_i (bank_pol_i),
  .addr_o     (addr_o),
  .rd_oe_o    (rd_oe_o),
  .cq_oe_o    (cq_oe_o),
  .open_i     (burst_open)
);

// File: tb/sim_sram_burst_ctl.sv
`timescale 1ns/1ps
module sim_sram_burst_ctl;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    cmd = 2'b00;
  logic [AW-1:0] addr = '0;
  logic          sel_n = 1'b1;
  logic [1:0]    ben = 2'b00;
  logic [1:0]    bpol = 2'b00;
  logic [AW-1:0] addr_o;
  logic          rd_oe_o, cq_oe_o;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  sram_burst_ctl #(.AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd), .addr_i(addr),
    .sel_ni(sel_n), .bank_en_i(ben), .bank_pol_i(bpol),
    .addr_o(addr_o), .rd_oe_o(rd_oe_o), .cq_oe_o(cq_oe_o)
  );

  typedef struct {
    logic [AW-1:0] a;
    logic          oe;
    logic          cq;
    string         tag;
  } exp_t;

  exp_t q[$];

  // reference model state
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic          m_open = 1'b0, m_rd = 1'b0;
  int            sel_hits[4];

  task automatic drive(input logic [1:0] c, input logic [AW-1:0] a, input logic sn,
                       input logic [1:0] en, input logic [1:0] pol, input string tag);
    logic bon, s, oe;
    exp_t e;
    @(negedge clk);
    cmd = c; addr = a; sel_n = sn; ben = en; bpol = pol;
    bon = (en == pol);
    s   = !sn && bon;
    oe  = 1'b0;
    if (s && (c == 2'b01 || c == 2'b10)) begin
      m_base = a; m_cnt = 2'b00; m_open = 1'b1; m_rd = (c == 2'b01); oe = m_rd;
    end else if (c == 2'b11) begin
      if (s && m_open) begin
        m_cnt = m_cnt + 2'd1; oe = m_rd;
      end
    end else begin
      m_open = 1'b0;
    end
    e.a   = {m_base[AW-1:2], m_base[1:0] + m_cnt};
    e.oe  = oe;
    e.cq  = bon;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares one expected item per cycle after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (addr_o !== e.a || rd_oe_o !== e.oe || cq_oe_o !== e.cq) begin
          n_fail++;
          $display("FAIL %s: got addr=%h oe=%b cq=%b exp addr=%h oe=%b cq=%b",
                   e.tag, addr_o, rd_oe_o, cq_oe_o, e.a, e.oe, e.cq);
        end else if (e.tag == "R5") begin
          if (rd_oe_o) sel_hits[ben]++;
        end
      end
    end
  end

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) sel_hits[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    n_run++;
    if (addr_o !== '0 || rd_oe_o !== 1'b0 || cq_oe_o !== 1'b1) begin
      n_fail++;
      $display("FAIL R9: got addr=%h oe=%b cq=%b exp 0 0 1", addr_o, rd_oe_o, cq_oe_o);
    end
    @(negedge clk); rst_ni = 1'b1;

    // R6: continue with no burst after reset
    drive(2'b11, 18'h00000, 1'b0, 2'b10, 2'b10, "R6");

    // R1/R2/R3/R8: read bursts from every low offset, with fourth-continue wrap
    for (int off = 0; off < 4; off++) begin
      drive(2'b01, 18'h2A5C0 | off, 1'b0, 2'b10, 2'b10, "R1");
      for (int k = 0; k < 3; k++) drive(2'b11, 18'h3FFFF, 1'b0, 2'b10, 2'b10, "R2");
      drive(2'b11, 18'h0, 1'b0, 2'b10, 2'b10, "R3");
    end

    // R8: write burst keeps output enable low
    drive(2'b10, 18'h3FFFE, 1'b0, 2'b01, 2'b01, "R8");
    drive(2'b11, 18'h0, 1'b0, 2'b01, 2'b01, "R8");
    drive(2'b11, 18'h0, 1'b0, 2'b01, 2'b01, "R2");

    // R6: continue while unselected via primary enable keeps burst open
    drive(2'b01, 18'h01235, 1'b0, 2'b11, 2'b11, "R1");
    drive(2'b11, 18'h0, 1'b1, 2'b11, 2'b11, "R6");
    drive(2'b11, 18'h0, 1'b0, 2'b11, 2'b11, "R2");
    // R7: unselected via bank enable, echo clock off; continue ignored
    drive(2'b11, 18'h0, 1'b0, 2'b01, 2'b11, "R7");
    drive(2'b11, 18'h0, 1'b1, 2'b00, 2'b11, "R7");
    drive(2'b11, 18'h0, 1'b0, 2'b11, 2'b11, "R2");

    // R4/R6/R8: deselect closes the burst, later continue ignored
    drive(2'b00, 18'h0, 1'b0, 2'b11, 2'b11, "R8");
    drive(2'b11, 18'h0, 1'b0, 2'b11, 2'b11, "R6");
    // R4: read while unselected closes burst
    drive(2'b01, 18'h00100, 1'b0, 2'b11, 2'b11, "R1");
    drive(2'b01, 18'h0FFFF, 1'b1, 2'b11, 2'b11, "R4");
    drive(2'b11, 18'h0, 1'b0, 2'b11, 2'b11, "R4");
    // R7: primary enable off, echo clock stays on
    drive(2'b00, 18'h0, 1'b1, 2'b00, 2'b00, "R7");

    // R4/R5: sweep every strap against every bank enable value
    for (int p = 0; p < 4; p++)
      for (int e = 0; e < 4; e++)
        drive(2'b01, 18'h00040 + AW'(4 * e), 1'b0, 2'(e), 2'(p), "R5");
    drive(2'b00, 18'h0, 1'b1, 2'b00, 2'b00, "R4");
    wait (q.size() == 0);
    @(negedge clk);
    for (int e = 0; e < 4; e++) begin
      n_run++;
      if (sel_hits[e] != 1) begin
        n_fail++;
        $display("FAIL R5: bank value %0d got %0d selected exp 1", e, sel_hits[e]);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule